// File: doc/BRIEF.md
# Remote DMA Host Port Engine

This block gives a host processor byte-serial or word-serial access to a local packet memory through one data port. Software first programs a 16-bit current address and a 16-bit remaining byte count. Each is loaded as two 8-bit register writes. Software also chooses byte or word width with a configuration bit. Every strobe on the data port then reads or writes memory at the current address and moves the address and count forward by the access size. When the count is used up, a completion flag is raised in the interrupt status byte.

The memory seen by the port has two regions. The first is a 32-byte station-address area at the bottom of the address space. At reset it holds a 6-byte station address, with each byte stored twice. The second is a packet window that starts at 16 KiB. Its size is a parameter, and the full-size window runs to 48 KiB. Addresses outside both regions ignore writes and read as all ones. The address pointer wraps inside a receive ring whose first page and end page are programmable.

A command register carries a halt bit, a run bit and the remote read and remote write request bits. A command that releases halt and requests a remote transfer while the count is already zero completes at once.

Top module: `rdma_host_port`

## Requirements
- R1: After reset the interrupt status reads 0x80, the current address and count read 0, the configuration reads 0 and the command reads 0x01. Station-area byte `a` holds station byte `a>>1` for `a` < 12 and 0 for `a` from 12 to 31. Station byte 0 is `STATION_ADDR[47:40]`.
- R2: The register map is: 0 command, 1 ring first page, 2 ring end page, 3 address low, 4 address high, 5 count low, 6 count high, 7 interrupt status, 8 configuration. Writing registers 3 to 6 loads one byte of the address or the count. Reading them returns the current address and the current count.
- R3: In byte mode (configuration bit 0 = 0), a data read returns `{8'h00, byte}` and a data write stores `dataWData[7:0]`. The address then rises by 1 and the count falls by 1.
- R4: In word mode (configuration bit 0 = 1), bit 0 of the access address is treated as 0. Data is little-endian: the low byte is at the even address and the high byte is at the odd address. The address then rises by 2 and the count falls by 2.
- R5: If the advanced address equals `{ring end page, 8'h00}`, it is replaced by `{ring first page, 8'h00}`.
- R6: If the count is nonzero and less than or equal to the access size, an access sets the count to 0 and sets interrupt status bit 6.
- R7: While the count is 0, data strobes leave the address and the count unchanged, and data writes do not modify memory.
- R8: Only addresses below 32, or inside the packet window starting at 16384, are backed by storage. Elsewhere, writes are ignored and reads return 0x00FF in byte mode and 0xFFFF in word mode.
- R9: A command write with bit 0 (halt) clear and bit 3 or bit 4 (remote read or remote write) set, while the count is 0, sets interrupt status bit 6 in that cycle. With a nonzero count it does not.
- R10: A command write with bit 0 clear clears interrupt status bit 7. Writing the interrupt status clears each of bits 6 to 0 whose written bit is 1, and never changes bit 7.
- R11: Read data appears on `dataRData` in the cycle after the read strobe. It comes from the address before that access. It holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register select |
| regWData | input | 8 | Register write data |
| regRData | output | 8 | Register read data, combinational on regAddr |
| dataRd | input | 1 | Data port read strobe |
| dataWr | input | 1 | Data port write strobe |
| dataWData | input | 16 | Data port write data |
| dataRData | output | 16 | Registered data port read data |

## Verification
Errors in the address or count register show up at the ports within one access. The next read returns a byte from the wrong location. The address and count readback registers also disagree with the model after every round. A wrong wrap or a wrong word-mode step sends later reads into the wrong region, where they return all ones or stale bytes. The completion flag and the reset flag are visible in interrupt status in the same cycle as the command or the final access that changes them. The model tracks every strobe, so a single lost decrement makes the flag arrive one access late.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] REG_CMD     = 4'd0;
  localparam logic [3:0] REG_FIRST   = 4'd1;
  localparam logic [3:0] REG_LAST    = 4'd2;
  localparam logic [3:0] REG_ADDR_LO = 4'd3;
  localparam logic [3:0] REG_ADDR_HI = 4'd4;
  localparam logic [3:0] REG_CNT_LO  = 4'd5;
  localparam logic [3:0] REG_CNT_HI  = 4'd6;
  localparam logic [3:0] REG_INT     = 4'd7;
  localparam logic [3:0] REG_CFG     = 4'd8;

  localparam int INT_DONE_BIT  = 6;
  localparam int INT_RESET_BIT = 7;

  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic memWe;
    logic memRe;
    logic step;
    logic wordMode;
  } rdmaCtl_t;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWData,
  output logic [7:0]  regRData,
  input  logic        dataRd,
  input  logic        dataWr,
  input  logic [15:0] curAddr,
  input  logic [15:0] remCnt,
  output rdmaCtl_t    ctl,
  output logic [7:0]  ringFirst,
  output logic [7:0]  ringLast,
  output logic [7:0]  intStatus
);
  logic [7:0]  cmdQ, cfgQ, isrQ, isrNext;
  logic [15:0] accSize;
  logic        cntZero, cntLast, cmdHit;

  assign accSize = cfgQ[0] ? 16'd2 : 16'd1;
  assign cntZero = (remCnt == 16'd0);
  assign cntLast = (remCnt <= accSize);
  assign cmdHit  = regWe && (regAddr == REG_CMD);

  always_comb begin
    ctl          = '0;
    ctl.ldAddrLo = regWe && (regAddr == REG_ADDR_LO);
    ctl.ldAddrHi = regWe && (regAddr == REG_ADDR_HI);
    ctl.ldCntLo  = regWe && (regAddr == REG_CNT_LO);
    ctl.ldCntHi  = regWe && (regAddr == REG_CNT_HI);
    ctl.memRe    = dataRd;
    ctl.memWe    = dataWr && !cntZero;
    ctl.step     = (dataRd || dataWr) && !cntZero;
    ctl.wordMode = cfgQ[0];
  end

  always_comb begin
    isrNext = isrQ;
    if (regWe && (regAddr == REG_INT))
      isrNext = isrQ & ~{1'b0, regWData[6:0]};
    if (cmdHit && !regWData[0]) begin
      isrNext[INT_RESET_BIT] = 1'b0;
      if ((regWData[4:3] != 2'b00) && cntZero)
        isrNext[INT_DONE_BIT] = 1'b1;
    end
    if (ctl.step && cntLast)
      isrNext[INT_DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ      <= 8'h01;
      cfgQ      <= 8'h00;
      ringFirst <= 8'h00;
      ringLast  <= 8'h00;
      isrQ      <= 8'h80;
    end else begin
      isrQ <= isrNext;
      if (regWe) begin
        case (regAddr)
          REG_CMD:   cmdQ      <= regWData;
          REG_FIRST: ringFirst <= regWData;
          REG_LAST:  ringLast  <= regWData;
          REG_CFG:   cfgQ      <= regWData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_CMD:     regRData = cmdQ;
      REG_FIRST:   regRData = ringFirst;
      REG_LAST:    regRData = ringLast;
      REG_ADDR_LO: regRData = curAddr[7:0];
      REG_ADDR_HI: regRData = curAddr[15:8];
      REG_CNT_LO:  regRData = remCnt[7:0];
      REG_CNT_HI:  regRData = remCnt[15:8];
      REG_INT:     regRData = isrQ;
      REG_CFG:     regRData = cfgQ;
      default:     regRData = 8'h00;
    endcase
  end

  assign intStatus = isrQ;
endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int          WIN_BASE     = 16384,
  parameter int          WIN_BYTES    = 512,
  parameter int          PROM_BYTES   = 32,
  parameter logic [47:0] STATION_ADDR = 48'h02A1B2C3D4E5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  rdmaCtl_t    ctl,
  input  logic [7:0]  regWData,
  input  logic [7:0]  ringFirst,
  input  logic [7:0]  ringLast,
  input  logic [15:0] dataWData,
  output logic [15:0] dataRData,
  output logic [15:0] curAddr,
  output logic [15:0] remCnt
);
  localparam int LANES      = 2;
  localparam int LANE_DEPTH = WIN_BYTES / LANES;
  localparam int LANE_IW    = $clog2(LANE_DEPTH);
  localparam int PROM_DEPTH = PROM_BYTES / LANES;
  localparam int PROM_IW    = $clog2(PROM_DEPTH);
  localparam int MAC_BYTES  = 6;

  logic [15:0]         accSize, sumAddr, nextAddr, nextCnt, effAddr;
  logic [16:0]         effWide;
  logic                inProm, inWin;
  logic [LANE_IW-1:0]  winIdx;
  logic [PROM_IW-1:0]  promIdx;
  logic [7:0]          laneRByte [LANES];

  assign accSize  = ctl.wordMode ? 16'd2 : 16'd1;
  assign sumAddr  = curAddr + accSize;
  assign nextAddr = (sumAddr == {ringLast, 8'h00}) ? {ringFirst, 8'h00} : sumAddr;
  assign nextCnt  = (remCnt <= accSize) ? 16'd0 : (remCnt - accSize);

  assign effAddr  = ctl.wordMode ? {curAddr[15:1], 1'b0} : curAddr;
  assign effWide  = {1'b0, effAddr};
  assign inProm   = effWide < 17'(PROM_BYTES);
  assign inWin    = (effWide >= 17'(WIN_BASE)) && (effWide < 17'(WIN_BASE + WIN_BYTES));
  assign winIdx   = LANE_IW'((effAddr - 16'(WIN_BASE)) >> 1);
  assign promIdx  = PROM_IW'(effAddr >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= 16'h0000;
      remCnt  <= 16'h0000;
    end else begin
      if (ctl.ldAddrLo)      curAddr[7:0]  <= regWData;
      else if (ctl.ldAddrHi) curAddr[15:8] <= regWData;
      else if (ctl.step)     curAddr       <= nextAddr;

      if (ctl.ldCntLo)       remCnt[7:0]   <= regWData;
      else if (ctl.ldCntHi)  remCnt[15:8]  <= regWData;
      else if (ctl.step)     remCnt        <= nextCnt;
    end
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [7:0] winMem  [LANE_DEPTH];
    logic [7:0] promMem [PROM_DEPTH];
    logic       laneSel;
    logic [7:0] laneWByte;

    assign laneSel   = ctl.wordMode || (effAddr[0] == L[0]);
    assign laneWByte = (ctl.wordMode && (L == 1)) ? dataWData[15:8] : dataWData[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PROM_DEPTH; i++)
          promMem[i] <= (i < MAC_BYTES) ? STATION_ADDR[47 - 8*i -: 8] : 8'h00;
      end else if (ctl.memWe && laneSel && inProm) begin
        promMem[promIdx] <= laneWByte;
      end
    end

    always_ff @(posedge clk) begin
      if (ctl.memWe && laneSel && inWin)
        winMem[winIdx] <= laneWByte;
    end

    assign laneRByte[L] = inProm ? promMem[promIdx] :
                          inWin  ? winMem[winIdx]   : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dataRData <= 16'h0000;
    else if (ctl.memRe)
      dataRData <= ctl.wordMode ? {laneRByte[1], laneRByte[0]}
                                : {8'h00, laneRByte[effAddr[0]]};
  end
endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
  import rdma_pkg::*;
#(
  parameter int          WIN_BASE     = 16384,
  parameter int          WIN_BYTES    = 512,
  parameter int          PROM_BYTES   = 32,
  parameter logic [47:0] STATION_ADDR = 48'h02A1B2C3D4E5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWData,
  output logic [7:0]  regRData,
  input  logic        dataRd,
  input  logic        dataWr,
  input  logic [15:0] dataWData,
  output logic [15:0] dataRData
);
  rdmaCtl_t    ctl;
  logic [15:0] curAddr, remCnt;
  logic [7:0]  ringFirst, ringLast, isrQ;
  logic        wordMode;

  assign wordMode = ctl.wordMode;

  rdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .dataRd(dataRd),
    .dataWr(dataWr), .curAddr(curAddr), .remCnt(remCnt), .ctl(ctl),
    .ringFirst(ringFirst), .ringLast(ringLast), .intStatus(isrQ)
  );

  rdma_datapath #(
    .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .PROM_BYTES(PROM_BYTES), .STATION_ADDR(STATION_ADDR)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .regWData(regWData),
    .ringFirst(ringFirst), .ringLast(ringLast), .dataWData(dataWData),
    .dataRData(dataRData), .curAddr(curAddr), .remCnt(remCnt)
  );
endmodule

// File: rtl/rdma_host_port_chk.sv
module rdma_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        regWe,
  input logic [3:0]  regAddr,
  input logic [7:0]  regWData,
  input logic        dataRd,
  input logic        dataWr,
  input logic [15:0] curAddr,
  input logic [15:0] remCnt,
  input logic [7:0]  isrQ,
  input logic        wordMode
);
  logic        strobe;
  logic [15:0] sz;
  assign strobe = (dataRd || dataWr) && !regWe;
  assign sz     = wordMode ? 16'd2 : 16'd1;

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (remCnt == 16'd0) |=> $stable(curAddr) && $stable(remCnt));

  assert_last_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (remCnt != 16'd0) && (remCnt <= sz) |=> (remCnt == 16'd0) && isrQ[6]);

  assert_count_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (remCnt > sz) |=> (remCnt < $past(remCnt)) && (remCnt != 16'd0));

  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && wordMode && (remCnt != 16'd0) |=> curAddr != $past(curAddr));

  assert_reset_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !isrQ[7] |=> !isrQ[7]);

  assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regWe && (regAddr == 4'd0) && !regWData[0] && (regWData[4:3] != 2'b00) &&
    (remCnt == 16'd0) |=> isrQ[6]);
endmodule

bind rdma_host_port rdma_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
  .regWData(regWData), .dataRd(dataRd), .dataWr(dataWr),
  .curAddr(curAddr), .remCnt(remCnt), .isrQ(isrQ), .wordMode(wordMode)
);

// File: tb/sim_rdma_host_port.sv
module sim_rdma_host_port;
  localparam int          WB  = 16384;
  localparam int          WS  = 512;
  localparam logic [47:0] MAC = 48'h02A1B2C3D4E5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        regWe = 1'b0, dataRd = 1'b0, dataWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWData = '0;
  logic [7:0]  regRData;
  logic [15:0] dataWData = '0;
  logic [15:0] dataRData;

  rdma_host_port u0 (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .dataRd(dataRd),
    .dataWr(dataWr), .dataWData(dataWData), .dataRData(dataRData)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0]  bprom [32];
  logic [7:0]  bwin  [WS];
  logic [15:0] baddr = 0, bcnt = 0;
  logic [7:0]  bstart = 0, bstop = 0, bisr = 8'h80;
  logic        bword = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] effA(input logic [15:0] a);
    return bword ? {a[15:1], 1'b0} : a;
  endfunction

  function automatic logic [7:0] getB(input int a);
    if (a < 32) return bprom[a];
    if (a >= WB && a < WB + WS) return bwin[a - WB];
    return 8'hFF;
  endfunction

  task automatic putB(input int a, input logic [7:0] v);
    if (a < 32) bprom[a] = v;
    else if (a >= WB && a < WB + WS) bwin[a - WB] = v;
  endtask

  function automatic logic [15:0] mread(input logic [15:0] a);
    int e;
    e = int'(effA(a));
    if (bword) return {getB(e + 1), getB(e)};
    return {8'h00, getB(e)};
  endfunction

  task automatic bstep();
    logic [15:0] sz, na;
    if (bcnt == 0) return;
    sz = bword ? 16'd2 : 16'd1;
    na = baddr + sz;
    if (na == {bstop, 8'h00}) na = {bstart, 8'h00};
    baddr = na;
    if (bcnt <= sz) begin
      bcnt = 0;
      bisr[6] = 1'b1;
    end else bcnt = bcnt - sz;
  endtask

  task automatic regW(input logic [3:0] a, input logic [7:0] v);
    regWe = 1'b1; regAddr = a; regWData = v;
    @(posedge clk); #1;
    regWe = 1'b0;
    case (a)
      4'd0: if (!v[0]) begin
              bisr[7] = 1'b0;
              if (v[4:3] != 2'b00 && bcnt == 0) bisr[6] = 1'b1;
            end
      4'd1: bstart = v;
      4'd2: bstop = v;
      4'd3: baddr[7:0] = v;
      4'd4: baddr[15:8] = v;
      4'd5: bcnt[7:0] = v;
      4'd6: bcnt[15:8] = v;
      4'd7: bisr = bisr & ~{1'b0, v[6:0]};
      4'd8: bword = v[0];
      default: ;
    endcase
  endtask

  task automatic regR(input logic [3:0] a, output logic [7:0] v);
    regAddr = a; #1;
    v = regRData;
  endtask

  task automatic setAddr(input logic [15:0] a);
    regW(4'd3, a[7:0]); regW(4'd4, a[15:8]);
  endtask

  task automatic setCnt(input logic [15:0] c);
    regW(4'd5, c[7:0]); regW(4'd6, c[15:8]);
  endtask

  task automatic dWrite(input logic [15:0] v);
    int e;
    dataWr = 1'b1; dataWData = v;
    @(posedge clk); #1;
    dataWr = 1'b0;
    if (bcnt != 0) begin
      e = int'(effA(baddr));
      putB(e, v[7:0]);
      if (bword) putB(e + 1, v[15:8]);
    end
    bstep();
  endtask

  task automatic dRead(input string tag, output logic [15:0] got);
    logic [15:0] exp;
    exp = mread(baddr);
    dataRd = 1'b1;
    @(posedge clk); #1;
    dataRd = 1'b0;
    bstep();
    got = dataRData;
    check(tag, got, exp);
  endtask

  task automatic checkState(input string tag);
    logic [7:0] lo, hi, s;
    regR(4'd3, lo); regR(4'd4, hi);
    check({tag, " address"}, {hi, lo}, baddr);
    regR(4'd5, lo); regR(4'd6, hi);
    check({tag, " count"}, {hi, lo}, bcnt);
    regR(4'd7, s);
    check({tag, " status"}, s, bisr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++)
      bprom[i] = (i / 2 < 6) ? MAC[47 - 8*(i/2) -: 8] : 8'h00;
    for (int i = 0; i < WS; i++) bwin[i] = 8'h00;

    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    regR(4'd7, v); check("R1 status", v, 8'h80);
    regR(4'd0, v); check("R1 command", v, 8'h01);
    regR(4'd8, v); check("R1 config", v, 8'h00);
    checkState("R1 reset");

    // R1 station area read back in byte mode
    setAddr(16'h0000); setCnt(16'd32);
    for (int i = 0; i < 32; i++) begin
      dRead("R1 station byte", d);
      if (i == 2) check("R1 station byte2 value", d, {8'h00, MAC[39:32]});
    end
    checkState("R6 after station read");

    // R2 loading in two halves
    setAddr(16'h1234); setCnt(16'hABCD);
    checkState("R2 load");

    // R10 status clear never touches bit 7
    regW(4'd7, 8'hFF);
    regR(4'd7, v); check("R10 status keeps bit7", v, 8'h80);
    regW(4'd0, 8'h22);
    regR(4'd7, v); check("R10 run clears bit7", v, 8'h00);

    // R9 zero-length start, and not with nonzero count
    setCnt(16'd0);
    regW(4'd0, 8'h0A);
    regR(4'd7, v); check("R9 zero length done", v, 8'h40);
    regW(4'd7, 8'h40);
    setCnt(16'd5);
    regW(4'd0, 8'h12);
    regR(4'd7, v); check("R9 nonzero count no done", v, 8'h00);

    // R3 byte writes, R6 completion, R7 suppressed write
    setAddr(16'h4000); setCnt(16'd5);
    dWrite(16'h00AA); dWrite(16'h00BB); dWrite(16'h00CC); dWrite(16'h00DD); dWrite(16'h0011);
    checkState("R6 byte done");
    regR(4'd7, v); check("R6 done bit", v[6], 1'b1);
    setAddr(16'h4004);
    dWrite(16'h00EE);
    checkState("R7 zero count write");
    dRead("R7 zero count read", d);
    checkState("R7 zero count read");
    setCnt(16'd1);
    dRead("R7 suppressed write", d);
    check("R7 byte kept", d, 16'h0011);

    // R3 byte reads and R11 hold
    setAddr(16'h4000); setCnt(16'd4);
    dRead("R3 byte read", d); check("R3 first byte", d, 16'h00AA);
    @(posedge clk); #1;
    check("R11 data held", dataRData, 16'h00AA);
    dRead("R3 byte read", d); check("R3 second byte", d, 16'h00BB);
    checkState("R3 step");

    // R4 word mode, odd address forced even
    regW(4'd8, 8'h01);
    setAddr(16'h4001); setCnt(16'd2);
    dRead("R4 word read", d); check("R4 little endian", d, 16'hBBAA);
    checkState("R4 step");
    setAddr(16'h4010); setCnt(16'd3);
    dWrite(16'h1234);
    checkState("R4 odd count");
    dWrite(16'h5678);
    checkState("R6 odd count done");
    regW(4'd8, 8'h00);
    setAddr(16'h4010); setCnt(16'd2);
    dRead("R4 low byte", d); check("R4 low byte value", d, 16'h0034);
    dRead("R4 high byte", d); check("R4 high byte value", d, 16'h0012);

    // R5 ring wrap
    regW(4'd1, 8'h40); regW(4'd2, 8'h42);
    regW(4'd8, 8'h01);
    setAddr(16'h41FE); setCnt(16'd4);
    dWrite(16'hCAFE);
    checkState("R5 wrap");
    check("R5 wrap address", baddr, 16'h4000);
    dWrite(16'hBEEF);
    setAddr(16'h4000); setCnt(16'd2);
    dRead("R5 after wrap", d); check("R5 written at first page", d, 16'hBEEF);

    // R8 unbacked region
    setAddr(16'h2000); setCnt(16'd4);
    dWrite(16'h5555);
    dRead("R8 word unbacked", d); check("R8 word ones", d, 16'hFFFF);
    regW(4'd8, 8'h00);
    setAddr(16'hC000); setCnt(16'd2);
    dWrite(16'h0055);
    setAddr(16'hC000);
    dRead("R8 byte unbacked", d); check("R8 byte ones", d, 16'h00FF);

    // Fill the window in word mode so random reads are defined
    regW(4'd8, 8'h01);
    setAddr(16'h4000); setCnt(16'd512);
    for (int i = 0; i < 256; i++) dWrite(16'($urandom));
    checkState("R5 fill");

    // Random rounds
    for (int r = 0; r < 200; r++) begin
      int sel;
      regW(4'd8, 8'($urandom % 2));
      regW(4'd7, 8'h7F);
      sel = $urandom % 8;
      if (sel == 0) setAddr(16'($urandom % 32));
      else if (sel == 1) setAddr(16'($urandom));
      else setAddr(16'(16'h4000 + $urandom % 512));
      setCnt(16'($urandom % 12));
      for (int k = 0; k < 8; k++) begin
        if ($urandom % 2) dWrite(16'($urandom));
        else dRead(bword ? "R4 random read" : "R3 random read", d);
      end
      checkState("R5 random round");
    end

    summary();
  end
endmodule